// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator processor core. It takes an operation code, the accumulator value, a second operand (the auxiliary register or a fetched byte) and the current carry, auxiliary-carry and overflow flags. One clock later it presents the new accumulator value, the new auxiliary register value and the next flags. Instruction decode, operand fetch and addressing sit outside the block. The surrounding core writes the outputs back into its architectural registers.

The block supports add, add with carry, subtract with borrow, increment, decrement, the bitwise operations, complement, clear, the four rotates, nibble swap, BCD decimal adjust, an unsigned 8x8 multiply and an unsigned 8/8 divide. The flag rules are those of a classic accumulator machine. There is only one subtract, and it always takes the carry in as the borrow. Overflow is the exclusive-or of the carries out of bits 6 and 7. Logic and increment/decrement operations leave the carry alone. A divide by zero is reported through the overflow flag.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs become zero. Every other result appears at the outputs on the rising edge after the inputs are applied, so latency is one clock.
- R2: Add (ADD) and add with carry (ADDC) produce the low 8 bits of accumulator + operand (+ carry in for ADDC). C is set when the unsigned sum exceeds FFh.
- R3: For ADD and ADDC, AC is set on a carry out of bit 3.
- R4: For ADD and ADDC, OV is the exclusive-or of the carry out of bit 6 and the carry out of bit 7. For example, 3Fh + D3h gives 12h with C=1, AC=1 and OV=0.
- R5: Subtract with borrow (SUBB) gives accumulator - operand - C. C is set on a borrow out of bit 7, AC is set on a borrow out of bit 3, and OV is set on two's-complement overflow.
- R6: Increment (INC) and decrement (DEC) wrap modulo 256 and pass all three flags through unchanged.
- R7: AND, OR, XOR, complement (CPL), clear (CLR), nibble swap (SWAP) and the plain rotates (RL, RR) pass all three flags through unchanged. SWAP exchanges the two nibbles.
- R8: Rotate through carry (RLC, RRC) rotates the 9-bit value formed by C and the accumulator. AC and OV pass through.
- R9: Decimal adjust (DA) works in two steps. It first adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble exceeds 9, or C is set, or the first step carried out; this second step sets C. C is never cleared, and AC and OV pass through.
- R10: Multiply (MUL) puts the high byte of the 16-bit product on the auxiliary output and the low byte on the accumulator output. It clears C and sets OV when the product exceeds FFh. AC passes through.
- R11: Divide (DIV) with a non-zero divisor puts the quotient on the accumulator output and the remainder on the auxiliary output. It clears C and OV. AC passes through.
- R12: Divide with a zero divisor sets OV and clears C. The accumulator and auxiliary results are unspecified.
- R13: For every operation other than MUL and DIV, the auxiliary output equals the operand input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 5 | Operation code (values of `alu_op_e`) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand / auxiliary register |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary-carry flag in |
| ov_i | input | 1 | Overflow flag in |
| acc_o | output | 8 | Accumulator result |
| aux_o | output | 8 | Auxiliary result (product high byte, remainder, or operand) |
| cy_o | output | 1 | Next carry flag |
| ac_o | output | 1 | Next auxiliary-carry flag |
| ov_o | output | 1 | Next overflow flag |

## Verification
The block holds no state beyond its output register, so a wrong internal value shows up at the ports on the very next clock. It appears either as a wrong result byte or as a flag that was recomputed when it should have passed through. The riskiest points are the flag-preservation rules, the borrow polarity of the subtract, the carry that the decimal adjust's first step can feed into its second step, and the zero-divisor case. Each of these is driven with operands that separate a correct flag from the likely wrong one, for example a carry-in of 1 on operations that must ignore it.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes shared by the ALU, its checker and the bench.
// Assumes a 5-bit operation field driven by the core's decoder.
package acc_alu_pkg;
    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CPL  = 5'd8,
        OP_CLR  = 5'd9,
        OP_RL   = 5'd10,
        OP_RR   = 5'd11,
        OP_RLC  = 5'd12,
        OP_RRC  = 5'd13,
        OP_SWAP = 5'd14,
        OP_DA   = 5'd15,
        OP_MUL  = 5'd16,
        OP_DIV  = 5'd17
    } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: adder/subtractor with nibble, bit-6 and bit-7 carry extraction.
// Subtract is done as a + ~b + ~cin, so borrows are inverted carries.
// Assumes W >= 5 so that both nibble and sign carries exist.
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         ac_out,
    output logic         ov_out
);
    logic [W-1:0] bx;
    logic         ci;
    logic [4:0]   lo_nib;
    logic [W-1:0] lo_sign;
    logic [W:0]   full;

    // Form operands, the three partial sums and the flags.
    always_comb begin
        bx      = sub ? ~b : b;
        ci      = sub ? ~cin : cin;
        lo_nib  = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'b0, ci};
        lo_sign = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, ci};
        full    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
        sum     = full[W-1:0];
        c_out   = sub ? ~full[W] : full[W];
        ac_out  = sub ? ~lo_nib[4] : lo_nib[4];
        ov_out  = lo_sign[W-1] ^ full[W];
    end
endmodule

// File: rtl/alu_muldiv.sv
// Module: unsigned W x W multiply and W / W restoring divide.
// The divide unrolls W compare-subtract steps; with a zero divisor
// its outputs are meaningless and dz_o is raised.
module alu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod_o,
    output logic [W-1:0]   quo_o,
    output logic [W-1:0]   rem_o,
    output logic           dz_o
);
    logic [W:0] part;

    // Full-width product.
    always_comb prod_o = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Restoring division, most significant dividend bit first.
    always_comb begin
        part  = '0;
        quo_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            part = {part[W-1:0], a[i]};
            if (part >= {1'b0, b}) begin
                part     = part - {1'b0, b};
                quo_o[i] = 1'b1;
            end
        end
        rem_o = part[W-1:0];
        dz_o  = (b == '0);
    end
endmodule

// File: rtl/alu_decadj.sv
// Module: BCD decimal adjust of an 8-bit sum after an addition.
// Assumes two packed BCD digits; the carry is only ever set here.
module alu_decadj (
    input  logic [7:0] a,
    input  logic       cy_i,
    input  logic       ac_i,
    output logic [7:0] res_o,
    output logic       cy_o
);
    logic [8:0] step1;
    logic [8:0] step2;
    logic       hi_fix;

    // Low-digit correction, then high-digit correction on the result.
    always_comb begin
        step1  = {1'b0, a} + ((a[3:0] > 4'd9 || ac_i) ? 9'h006 : 9'h000);
        hi_fix = cy_i || step1[8] || (step1[7:4] > 4'd9);
        step2  = {1'b0, step1[7:0]} + (hi_fix ? 9'h060 : 9'h000);
        res_o  = step2[7:0];
        cy_o   = cy_i | hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Selects among the arithmetic units and
// the in-line logic/rotate results, computes next flags and registers
// everything for one-cycle latency. Synchronous active-low reset.
module acc_alu #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         cy_i,
    input  logic         ac_i,
    input  logic         ov_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] aux_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
);
    import acc_alu_pkg::*;

    localparam int HALF = W / 2;

    alu_op_e        op;
    logic [W-1:0]   as_sum;
    logic           as_c, as_ac, as_ov;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;
    logic           dz;
    logic [7:0]     da_res;
    logic           da_cy;
    logic [W-1:0]   nxt_acc, nxt_aux;
    logic           nxt_cy, nxt_ac, nxt_ov;

    assign op = alu_op_e'(op_i);

    alu_addsub #(.W(W)) u_addsub (
        .a      (acc_i),
        .b      (opnd_i),
        .cin    ((op == OP_ADD) ? 1'b0 : cy_i),
        .sub    (op == OP_SUBB),
        .sum    (as_sum),
        .c_out  (as_c),
        .ac_out (as_ac),
        .ov_out (as_ov)
    );

    alu_muldiv #(.W(W)) u_muldiv (
        .a      (acc_i),
        .b      (opnd_i),
        .prod_o (prod),
        .quo_o  (quo),
        .rem_o  (rem),
        .dz_o   (dz)
    );

    alu_decadj u_decadj (
        .a     (acc_i[7:0]),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    // Result and next-flag selection by operation.
    always_comb begin
        nxt_acc = acc_i;
        nxt_aux = opnd_i;
        nxt_cy  = cy_i;
        nxt_ac  = ac_i;
        nxt_ov  = ov_i;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                nxt_acc = as_sum;
                nxt_cy  = as_c;
                nxt_ac  = as_ac;
                nxt_ov  = as_ov;
            end
            OP_INC:  nxt_acc = acc_i + 1'b1;
            OP_DEC:  nxt_acc = acc_i - 1'b1;
            OP_AND:  nxt_acc = acc_i & opnd_i;
            OP_OR:   nxt_acc = acc_i | opnd_i;
            OP_XOR:  nxt_acc = acc_i ^ opnd_i;
            OP_CPL:  nxt_acc = ~acc_i;
            OP_CLR:  nxt_acc = '0;
            OP_RL:   nxt_acc = {acc_i[W-2:0], acc_i[W-1]};
            OP_RR:   nxt_acc = {acc_i[0], acc_i[W-1:1]};
            OP_RLC: begin
                nxt_acc = {acc_i[W-2:0], cy_i};
                nxt_cy  = acc_i[W-1];
            end
            OP_RRC: begin
                nxt_acc = {cy_i, acc_i[W-1:1]};
                nxt_cy  = acc_i[0];
            end
            OP_SWAP: nxt_acc = {acc_i[HALF-1:0], acc_i[W-1:HALF]};
            OP_DA: begin
                nxt_acc = W'(da_res);
                nxt_cy  = da_cy;
            end
            OP_MUL: begin
                nxt_acc = prod[W-1:0];
                nxt_aux = prod[2*W-1:W];
                nxt_cy  = 1'b0;
                nxt_ov  = |prod[2*W-1:W];
            end
            OP_DIV: begin
                nxt_acc = quo;
                nxt_aux = rem;
                nxt_cy  = 1'b0;
                nxt_ov  = dz;
            end
            default: ;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
            aux_o <= '0;
            cy_o  <= 1'b0;
            ac_o  <= 1'b0;
            ov_o  <= 1'b0;
        end else begin
            acc_o <= nxt_acc;
            aux_o <= nxt_aux;
            cy_o  <= nxt_cy;
            ac_o  <= nxt_ac;
            ov_o  <= nxt_ov;
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
// Module: property checker for acc_alu, attached by bind.
// Every property looks one cycle back, and only when the previous
// cycle was also out of reset.
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   op_i,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic         cy_i,
    input logic         ac_i,
    input logic         ov_i,
    input logic [W-1:0] acc_o,
    input logic [W-1:0] aux_o,
    input logic         cy_o,
    input logic         ac_o,
    input logic         ov_o
);
    import acc_alu_pkg::*;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && aux_o == '0 && !cy_o && !ac_o && !ov_o));

    // R6
    incdec_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC)
        |=> (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

    // R7
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_SWAP)
        |=> (cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i)));

    // R8
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_RLC |=> (cy_o == $past(acc_i[W-1]) && acc_o[0] == $past(cy_i)));

    // R10
    mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MUL |=> (!cy_o && ov_o == (aux_o != '0)));

    // R12
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DIV && opnd_i == '0) |=> (ov_o && !cy_o));

    // R11
    div_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DIV && opnd_i != '0) |=> (!ov_o && !cy_o && aux_o < $past(opnd_i)));

    // R13
    aux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_MUL && op_i != OP_DIV) |=> aux_o == $past(opnd_i));

    // R9
    da_carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DA && cy_i) |=> cy_o);
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (.*);

// File: tb/acc_alu_tb.sv
// Directed bench for acc_alu: one task per scenario, each checking its results.
module acc_alu_tb;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
    logic [7:0] acc_o, aux_o;
    logic       cy_o, ac_o, ov_o;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i), .acc_o(acc_o), .aux_o(aux_o),
        .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
    );

    // Compare one value and record the outcome.
    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one operation, wait for its registered result.
    task automatic run(input alu_op_e op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic ac, input logic ov);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; cy_i = c; ac_i = ac; ov_i = ov;
        @(posedge clk);
        #1;
    endtask

    // Check accumulator and the three flags {C,AC,OV}.
    task automatic expect_res(input string req, input logic [7:0] a, input logic [2:0] f);
        chk(req, {8'h00, acc_o}, {8'h00, a});
        chk(req, {13'h0, cy_o, ac_o, ov_o}, {13'h0, f});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        run(OP_ADD, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
        chk("R1 acc", {8'h0, acc_o}, 16'h0);
        chk("R1 aux/flags", {aux_o, 5'h0, cy_o, ac_o, ov_o}, 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run(OP_ADD, 8'h3F, 8'hD3, 1'b1, 1'b0, 1'b1);
        expect_res("R4 3F+D3", 8'h12, 3'b110);
        run(OP_ADD, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
        expect_res("R4 7F+01 ov", 8'h80, 3'b011);
        run(OP_ADDC, 8'h10, 8'h20, 1'b1, 1'b1, 1'b1);
        expect_res("R2 addc", 8'h31, 3'b000);
        run(OP_ADDC, 8'hF8, 8'h08, 1'b0, 1'b0, 1'b0);
        expect_res("R3 addc carry", 8'h00, 3'b110);
    endtask

    task automatic t_subb();
        run(OP_SUBB, 8'h50, 8'h4F, 1'b0, 1'b0, 1'b1);
        expect_res("R5 50-4F", 8'h01, 3'b010);
        run(OP_SUBB, 8'h50, 8'h4F, 1'b1, 1'b0, 1'b0);
        expect_res("R5 50-4F-1", 8'h00, 3'b010);
        run(OP_SUBB, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
        expect_res("R5 borrow", 8'hFF, 3'b110);
        run(OP_SUBB, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0);
        expect_res("R5 ov", 8'h7F, 3'b011);
    endtask

    task automatic t_incdec();
        run(OP_INC, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1);
        expect_res("R6 inc wrap", 8'h00, 3'b101);
        run(OP_DEC, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        expect_res("R6 dec wrap", 8'hFF, 3'b010);
    endtask

    task automatic t_logic();
        run(OP_AND, 8'hF0, 8'h3C, 1'b1, 1'b1, 1'b0); expect_res("R7 and", 8'h30, 3'b110);
        run(OP_OR,  8'hF0, 8'h3C, 1'b1, 1'b1, 1'b0); expect_res("R7 or", 8'hFC, 3'b110);
        run(OP_XOR, 8'hF0, 8'h3C, 1'b1, 1'b1, 1'b0); expect_res("R7 xor", 8'hCC, 3'b110);
        run(OP_CPL, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b1); expect_res("R7 cpl", 8'hA5, 3'b001);
        run(OP_CLR, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b1); expect_res("R7 clr", 8'h00, 3'b101);
        run(OP_SWAP, 8'h72, 8'h00, 1'b1, 1'b1, 1'b1); expect_res("R7 swap", 8'h27, 3'b111);
        run(OP_RL,  8'h81, 8'h00, 1'b0, 1'b1, 1'b0); expect_res("R7 rl", 8'h03, 3'b010);
        run(OP_RR,  8'h81, 8'h00, 1'b0, 1'b1, 1'b0); expect_res("R7 rr", 8'hC0, 3'b010);
    endtask

    task automatic t_rot_carry();
        run(OP_RLC, 8'h3C, 8'h00, 1'b1, 1'b1, 1'b1); expect_res("R8 rlc", 8'h79, 3'b011);
        run(OP_RRC, 8'hBD, 8'h00, 1'b0, 1'b1, 1'b0); expect_res("R8 rrc", 8'h5E, 3'b110);
    endtask

    task automatic t_da();
        run(OP_DA, 8'h4C, 8'h00, 1'b0, 1'b0, 1'b1); expect_res("R9 4C", 8'h52, 3'b001);
        run(OP_DA, 8'h9A, 8'h00, 1'b0, 1'b0, 1'b0); expect_res("R9 9A", 8'h00, 3'b100);
        run(OP_DA, 8'h12, 8'h00, 1'b0, 1'b1, 1'b0); expect_res("R9 ac fix", 8'h18, 3'b010);
        run(OP_DA, 8'h30, 8'h00, 1'b1, 1'b0, 1'b0); expect_res("R9 c fix", 8'h90, 3'b100);
    endtask

    task automatic t_mul();
        run(OP_MUL, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0);
        expect_res("R10 FFxFF", 8'h01, 3'b011);
        chk("R10 FFxFF high", {8'h0, aux_o}, 16'h00FE);
        run(OP_MUL, 8'h0C, 8'h0A, 1'b1, 1'b0, 1'b1);
        expect_res("R10 0Cx0A", 8'h78, 3'b000);
        chk("R10 0Cx0A high", {8'h0, aux_o}, 16'h0000);
    endtask

    task automatic t_div();
        run(OP_DIV, 8'hFB, 8'h12, 1'b1, 1'b1, 1'b1);
        expect_res("R11 FB/12", 8'h0D, 3'b010);
        chk("R11 rem", {8'h0, aux_o}, 16'h0011);
        run(OP_DIV, 8'h07, 8'h09, 1'b1, 1'b0, 1'b0);
        expect_res("R11 07/09", 8'h00, 3'b000);
        chk("R11 rem small", {8'h0, aux_o}, 16'h0007);
        run(OP_DIV, 8'h55, 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R12 div zero flags", {14'h0, cy_o, ov_o}, 16'h0001);
    endtask

    task automatic t_aux_pass();
        run(OP_ADD, 8'h01, 8'hD3, 1'b0, 1'b0, 1'b0);
        chk("R13 add aux", {8'h0, aux_o}, 16'h00D3);
        run(OP_SWAP, 8'h01, 8'h6E, 1'b0, 1'b0, 1'b0);
        chk("R13 swap aux", {8'h0, aux_o}, 16'h006E);
    endtask

    initial begin
        t_reset();
        t_add();
        t_subb();
        t_incdec();
        t_logic();
        t_rot_carry();
        t_da();
        t_mul();
        t_div();
        t_aux_pass();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule